// File: doc/BRIEF.md
# Scoreboard Issue and Completion Controller

This block is the central hazard tracker for a machine that issues decoded instructions in program order to a small pool of non-pipelined execution units and lets those units finish in any order. Each cycle it may accept one instruction, which carries an operation class, a destination register and two source register numbers. It holds a status record for every unit and a pending-writer tag for every architectural register. From these it decides when each unit may read its operands from the register file and when a finished unit may write its result back.

The pool has five units: one integer/memory unit, two multipliers, one adder and one divider. Each unit's arithmetic is stood in for by a countdown timer, so the block produces operand-read grants, execution-start pulses, done pulses and write-result grants that a register file and real datapaths would follow. There is no forwarding. A consumer reads a produced value from the register file no earlier than the cycle after the producer's write-back. A quiescent flag reports when every unit is idle.

Top module: `scoreboard_sched`

## Requirements
- R1: While reset is held and in the first cycle after it is released, every read, write, start and done output is zero, `quiescent` is 1 and `issueTag` is 0. With `inValid` low and any operands, `inReady` is 1.
- R2: `inReady` is 1 exactly when a unit of the requested class is idle and no busy unit is due to write `inDest`, whether or not `inValid` is high. An instruction that is offered but not accepted stays at the input, and no later instruction can pass it. A pending write to the same destination therefore blocks issue until that write completes.
- R3: Operation classes are coded as 0 integer/memory, 1 multiply, 2 add, 3 divide. Unit tags are 1 for integer, 2 and 3 for the multipliers, 4 for the adder and 5 for the divider, and 0 means none. When both multipliers are idle, tag 2 is chosen. In a cycle where an instruction is accepted, `issueTag` shows the tag it was given, and otherwise 0.
- R4: Bit u-1 of `readGrant` goes high for unit tag u when that unit is waiting to read and both of its sources are marked ready. The grant lasts one cycle, and several units may be granted in the same cycle. The earliest read is the cycle after issue.
- R5: A unit whose execution has finished is granted write-back only if no other unit still has an unread source equal to its destination. Otherwise it waits, holding its result.
- R6: A write-back marks ready every waiting source whose producer is the writing unit, so that source's reader can be granted in the next cycle. An instruction accepted in the same cycle as its source's producer writes back takes that source as already ready.
- R7: A unit's `execStart` bit pulses in the cycle after its read grant. Its `unitDone` bit pulses in the last of L execution cycles, where L is 1 for integer, 10 for multiply, 2 for add and 40 for divide. Write-back can come no earlier than the next cycle, and the unit becomes free for issue in the cycle after write-back.
- R8: Several finished units with no hazard are granted write-back in the same cycle.
- R9: `quiescent` is 1 exactly when no unit holds an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An instruction is offered |
| inOp | input | 2 | Operation class of the offered instruction |
| inDest | input | 5 | Destination register |
| inSrc1 | input | 5 | First source register |
| inSrc2 | input | 5 | Second source register |
| inReady | output | 1 | Offered instruction can be accepted this cycle |
| issueTag | output | 3 | Unit tag given to the instruction accepted this cycle |
| readGrant | output | 5 | Per-unit operand-read grant |
| execStart | output | 5 | Per-unit first-execution-cycle pulse |
| unitDone | output | 5 | Per-unit end-of-execution pulse |
| writeGrant | output | 5 | Per-unit write-back grant |
| quiescent | output | 1 | No unit is busy |

## Verification
The case that needs care is the same-cycle meeting of a producer's write-back and the acceptance of an instruction that reads the produced register. If the new entry recorded the producer as still pending, it would never see the broadcast and would wait forever. A directed sequence holds the input idle so that an add's write-back lands exactly in the cycle a multiply reading that register is accepted. The multiply must then be granted its read in the very next cycle. This is judged both by a per-cycle comparison with a behavioural model and by the recorded stage cycles. Simultaneous write-backs of two units and a read that clears a WAR hold are checked in the same way.

// File: rtl/sched_pkg.sv
package sched_pkg;

  localparam int NUM_UNITS = 5;
  localparam int TAG_W     = $clog2(NUM_UNITS + 1);

  localparam int UNIT_INT  = 0;
  localparam int UNIT_MUL0 = 1;
  localparam int UNIT_MUL1 = 2;
  localparam int UNIT_ADD  = 3;
  localparam int UNIT_DIV  = 4;

  typedef enum logic [1:0] {
    OP_INT = 2'd0,
    OP_MUL = 2'd1,
    OP_ADD = 2'd2,
    OP_DIV = 2'd3
  } opClass_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_EXEC,
    ST_WRITE
  } unitStage_t;

  typedef struct packed {
    logic [NUM_UNITS-1:0] readGo;
    logic [NUM_UNITS-1:0] writeGo;
  } ctrlStrobe_t;

  function automatic logic [1:0] unitClassOf(input int unitIdx);
    case (unitIdx)
      UNIT_INT:             unitClassOf = OP_INT;
      UNIT_MUL0, UNIT_MUL1: unitClassOf = OP_MUL;
      UNIT_ADD:             unitClassOf = OP_ADD;
      default:              unitClassOf = OP_DIV;
    endcase
  endfunction

endpackage

// File: rtl/sched_timer.sv
module sched_timer
  import sched_pkg::*;
#(
  parameter int LAT_INT = 1,
  parameter int LAT_MUL = 10,
  parameter int LAT_ADD = 2,
  parameter int LAT_DIV = 40
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  output logic [NUM_UNITS-1:0] execStart,
  output logic [NUM_UNITS-1:0] unitDone
);

  localparam int MAX_A   = (LAT_INT > LAT_MUL) ? LAT_INT : LAT_MUL;
  localparam int MAX_B   = (LAT_ADD > LAT_DIV) ? LAT_ADD : LAT_DIV;
  localparam int MAX_LAT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    localparam int LAT = (u == UNIT_INT) ? LAT_INT :
                         (u == UNIT_ADD) ? LAT_ADD :
                         (u == UNIT_DIV) ? LAT_DIV : LAT_MUL;

    logic [CNT_W-1:0] cnt;
    logic             startPend;
    logic             resultHeld;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt        <= '0;
        startPend  <= 1'b0;
        resultHeld <= 1'b0;
      end else begin
        startPend <= strobe.readGo[u];
        if (strobe.readGo[u]) begin
          cnt <= CNT_W'(LAT);
        end else if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end
        if (cnt == CNT_W'(1)) begin
          resultHeld <= 1'b1;
        end else if (strobe.writeGo[u]) begin
          resultHeld <= 1'b0;
        end
      end
    end

    assign execStart[u] = startPend;
    assign unitDone[u]  = (cnt == CNT_W'(1));

    // R5
    write_needs_result_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.writeGo[u] |-> resultHeld);

    // R4
    read_only_when_free_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.readGo[u] |-> (cnt == '0) && !resultHeld);
  end

endmodule

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import sched_pkg::*;
#(
  parameter int REGS = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [1:0]               inOp,
  input  logic [$clog2(REGS)-1:0]  inDest,
  input  logic [$clog2(REGS)-1:0]  inSrc1,
  input  logic [$clog2(REGS)-1:0]  inSrc2,
  output logic                     inReady,
  output logic [TAG_W-1:0]         issueTag,
  input  logic [NUM_UNITS-1:0]     unitDone,
  output ctrlStrobe_t              strobe,
  output logic                     quiescent
);

  localparam int RW       = $clog2(REGS);
  localparam int TAG_SPAN = 1 << TAG_W;

  unitStage_t           stage [NUM_UNITS];
  logic [RW-1:0]        fi    [NUM_UNITS];
  logic [RW-1:0]        fj    [NUM_UNITS];
  logic [RW-1:0]        fk    [NUM_UNITS];
  logic [TAG_W-1:0]     qj    [NUM_UNITS];
  logic [TAG_W-1:0]     qk    [NUM_UNITS];
  logic [NUM_UNITS-1:0] rj;
  logic [NUM_UNITS-1:0] rk;
  logic [TAG_W-1:0]     regResult [REGS];

  logic                 pickFound;
  logic [TAG_W-1:0]     pickTag;
  logic                 fire;
  logic [TAG_SPAN-1:0]  wroteTag;
  logic [TAG_SPAN-1:0]  busyByTag;
  logic [TAG_W-1:0]     srcTag1, srcTag2;
  logic                 src1Ready, src2Ready;
  logic [NUM_UNITS-1:0] warBlock;

  // Issue side: lowest idle unit of the requested class.
  always_comb begin
    pickFound = 1'b0;
    pickTag   = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (!pickFound && stage[u] == ST_IDLE && unitClassOf(u) == inOp) begin
        pickFound = 1'b1;
        pickTag   = TAG_W'(u + 1);
      end
    end
  end

  assign inReady  = pickFound && (regResult[inDest] == '0);
  assign fire     = inValid && inReady;
  assign issueTag = fire ? pickTag : '0;

  // Write side: hold a finished unit while any other unit still owes a read
  // of the register it is about to overwrite.
  always_comb begin
    warBlock = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      for (int f = 0; f < NUM_UNITS; f++) begin
        if (f != u && ((rj[f] && fj[f] == fi[u]) || (rk[f] && fk[f] == fi[u]))) begin
          warBlock[u] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++) begin
      strobe.readGo[u]  = (stage[u] == ST_READ) && rj[u] && rk[u];
      strobe.writeGo[u] = (stage[u] == ST_WRITE) && !warBlock[u];
    end
  end

  always_comb begin
    wroteTag  = '0;
    busyByTag = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      wroteTag[u+1]  = strobe.writeGo[u];
      busyByTag[u+1] = (stage[u] != ST_IDLE);
    end
  end

  // A producer writing back this very cycle counts as already delivered.
  assign srcTag1   = regResult[inSrc1];
  assign srcTag2   = regResult[inSrc2];
  assign src1Ready = (srcTag1 == '0) || wroteTag[srcTag1];
  assign src2Ready = (srcTag2 == '0) || wroteTag[srcTag2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int u = 0; u < NUM_UNITS; u++) begin
        stage[u] <= ST_IDLE;
        fi[u]    <= '0;
        fj[u]    <= '0;
        fk[u]    <= '0;
        qj[u]    <= '0;
        qk[u]    <= '0;
      end
      rj <= '0;
      rk <= '0;
    end else begin
      for (int u = 0; u < NUM_UNITS; u++) begin
        case (stage[u])
          ST_IDLE: begin
            if (fire && pickTag == TAG_W'(u + 1)) begin
              stage[u] <= ST_READ;
              fi[u]    <= inDest;
              fj[u]    <= inSrc1;
              fk[u]    <= inSrc2;
              qj[u]    <= src1Ready ? '0 : srcTag1;
              qk[u]    <= src2Ready ? '0 : srcTag2;
              rj[u]    <= src1Ready;
              rk[u]    <= src2Ready;
            end
          end
          ST_READ: begin
            if (strobe.readGo[u]) begin
              stage[u] <= ST_EXEC;
              rj[u]    <= 1'b0;
              rk[u]    <= 1'b0;
              qj[u]    <= '0;
              qk[u]    <= '0;
            end else begin
              if (qj[u] != '0 && wroteTag[qj[u]]) rj[u] <= 1'b1;
              if (qk[u] != '0 && wroteTag[qk[u]]) rk[u] <= 1'b1;
            end
          end
          ST_EXEC: begin
            if (unitDone[u]) stage[u] <= ST_WRITE;
          end
          default: begin
            if (strobe.writeGo[u]) stage[u] <= ST_IDLE;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < REGS; r++) regResult[r] <= '0;
    end else begin
      for (int u = 0; u < NUM_UNITS; u++) begin
        if (strobe.writeGo[u]) regResult[fi[u]] <= '0;
      end
      if (fire) regResult[inDest] <= pickTag;
    end
  end

  always_comb begin
    quiescent = 1'b1;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (stage[u] != ST_IDLE) quiescent = 1'b0;
    end
  end

  // R9
  quiet_no_grants_chk: assert property (@(posedge clk) disable iff (!rstN)
    quiescent |-> (strobe.readGo == '0) && (strobe.writeGo == '0));

  for (genvar r = 0; r < REGS; r++) begin : g_regChk
    // R2
    pending_owner_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
      (regResult[r] != '0) |-> busyByTag[regResult[r]]);
  end

  for (genvar a = 0; a < NUM_UNITS; a++) begin : g_pairA
    for (genvar b = a + 1; b < NUM_UNITS; b++) begin : g_pairB
      // R8
      distinct_write_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.writeGo[a] && strobe.writeGo[b]) |-> (fi[a] != fi[b]));
    end
  end

endmodule

// File: rtl/scoreboard_sched.sv
module scoreboard_sched
  import sched_pkg::*;
#(
  parameter int REGS    = 32,
  parameter int LAT_INT = 1,
  parameter int LAT_MUL = 10,
  parameter int LAT_ADD = 2,
  parameter int LAT_DIV = 40
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [1:0]              inOp,
  input  logic [$clog2(REGS)-1:0] inDest,
  input  logic [$clog2(REGS)-1:0] inSrc1,
  input  logic [$clog2(REGS)-1:0] inSrc2,
  output logic                    inReady,
  output logic [TAG_W-1:0]        issueTag,
  output logic [NUM_UNITS-1:0]    readGrant,
  output logic [NUM_UNITS-1:0]    execStart,
  output logic [NUM_UNITS-1:0]    unitDone,
  output logic [NUM_UNITS-1:0]    writeGrant,
  output logic                    quiescent
);

  ctrlStrobe_t strobe;

  sched_ctrl #(
    .REGS(REGS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inOp     (inOp),
    .inDest   (inDest),
    .inSrc1   (inSrc1),
    .inSrc2   (inSrc2),
    .inReady  (inReady),
    .issueTag (issueTag),
    .unitDone (unitDone),
    .strobe   (strobe),
    .quiescent(quiescent)
  );

  sched_timer #(
    .LAT_INT(LAT_INT),
    .LAT_MUL(LAT_MUL),
    .LAT_ADD(LAT_ADD),
    .LAT_DIV(LAT_DIV)
  ) u_timer (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .execStart(execStart),
    .unitDone (unitDone)
  );

  assign readGrant  = strobe.readGo;
  assign writeGrant = strobe.writeGo;

endmodule

// File: tb/scoreboard_sched_bench.sv
`timescale 1ns/1ps
module scoreboard_sched_bench;

  localparam int NU = 5;
  localparam int MAXI = 1024;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [1:0] inOp = '0;
  logic [4:0] inDest = '0, inSrc1 = '0, inSrc2 = '0;
  logic       inReady;
  logic [2:0] issueTag;
  logic [4:0] readGrant, execStart, unitDone, writeGrant;
  logic       quiescent;

  always #2.5 clk = ~clk;

  scoreboard_sched u_scoreboard_sched (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp),
    .inDest(inDest), .inSrc1(inSrc1), .inSrc2(inSrc2),
    .inReady(inReady), .issueTag(issueTag), .readGrant(readGrant),
    .execStart(execStart), .unitDone(unitDone), .writeGrant(writeGrant),
    .quiescent(quiescent)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // program to drive
  int nInstr;
  int pOp [MAXI];
  int pD  [MAXI];
  int pS1 [MAXI];
  int pS2 [MAXI];
  int pGap[MAXI];
  int issueCyc[MAXI];
  int readCyc [MAXI];
  int doneCyc [MAXI];
  int writeCyc[MAXI];
  int tagRec  [MAXI];
  int unitInst[NU];

  // behavioural model state
  int mStage[NU];
  int mFi[NU], mFj[NU], mFk[NU], mQj[NU], mQk[NU], mRem[NU];
  bit mRj[NU], mRk[NU], mFirst[NU];
  int mReg[32];
  bit eReady, eQuiet;
  int ePick, eTag;
  bit [4:0] eRd, eWr, eSt, eDn;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  function automatic int clsOf(input int u);
    if (u == 0) return 0;
    if (u <= 2) return 1;
    if (u == 3) return 2;
    return 3;
  endfunction

  function automatic int latOf(input int u);
    if (u == 0) return 1;
    if (u <= 2) return 10;
    if (u == 3) return 2;
    return 40;
  endfunction

  task automatic modelReset();
    for (int u = 0; u < NU; u++) begin
      mStage[u] = 0; mFi[u] = 0; mFj[u] = 0; mFk[u] = 0;
      mQj[u] = 0; mQk[u] = 0; mRem[u] = 0;
      mRj[u] = 0; mRk[u] = 0; mFirst[u] = 0;
    end
    for (int r = 0; r < 32; r++) mReg[r] = 0;
  endtask

  task automatic modelEval(input bit v, input int op, input int d);
    ePick = -1;
    for (int u = 0; u < NU; u++)
      if (ePick < 0 && mStage[u] == 0 && clsOf(u) == op) ePick = u;
    eReady = (ePick >= 0) && (mReg[d] == 0);
    eTag   = (v && eReady) ? ePick + 1 : 0;
    eQuiet = 1'b1;
    for (int u = 0; u < NU; u++) begin
      bit held;
      if (mStage[u] != 0) eQuiet = 1'b0;
      eRd[u] = (mStage[u] == 1) && mRj[u] && mRk[u];
      eSt[u] = (mStage[u] == 2) && mFirst[u];
      eDn[u] = (mStage[u] == 2) && (mRem[u] == 1);
      held = 1'b0;
      for (int f = 0; f < NU; f++)
        if (f != u && ((mRj[f] && mFj[f] == mFi[u]) || (mRk[f] && mFk[f] == mFi[u]))) held = 1'b1;
      eWr[u] = (mStage[u] == 3) && !held;
    end
  endtask

  task automatic modelAdvance(input bit v, input int op, input int d, input int s1, input int s2);
    int q1, q2;
    q1 = mReg[s1];
    if (q1 != 0 && eWr[q1-1]) q1 = 0;
    q2 = mReg[s2];
    if (q2 != 0 && eWr[q2-1]) q2 = 0;
    for (int u = 0; u < NU; u++) begin
      if (mStage[u] == 1) begin
        if (eRd[u]) begin
          mStage[u] = 2; mRem[u] = latOf(u); mFirst[u] = 1;
          mRj[u] = 0; mRk[u] = 0; mQj[u] = 0; mQk[u] = 0;
        end else begin
          if (mQj[u] != 0 && eWr[mQj[u]-1]) mRj[u] = 1;
          if (mQk[u] != 0 && eWr[mQk[u]-1]) mRk[u] = 1;
        end
      end else if (mStage[u] == 2) begin
        mFirst[u] = 0;
        mRem[u]--;
        if (mRem[u] == 0) mStage[u] = 3;
      end else if (mStage[u] == 3) begin
        if (eWr[u]) begin
          mReg[mFi[u]] = 0;
          mStage[u] = 0;
        end
      end
    end
    if (v && eReady && op >= 0) begin
      mStage[ePick] = 1;
      mFi[ePick] = d; mFj[ePick] = s1; mFk[ePick] = s2;
      mQj[ePick] = q1; mQk[ePick] = q2;
      mRj[ePick] = (q1 == 0); mRk[ePick] = (q2 == 0);
      mReg[d] = ePick + 1;
    end
  endtask

  task automatic compareAll();
    chk("R2", "inReady", inReady, eReady);
    chk("R3", "issueTag", issueTag, eTag);
    chk("R4 R6", "readGrant", readGrant, eRd);
    chk("R7", "execStart", execStart, eSt);
    chk("R7", "unitDone", unitDone, eDn);
    chk("R5 R8", "writeGrant", writeGrant, eWr);
    chk("R9", "quiescent", quiescent, eQuiet);
  endtask

  // Runs the loaded program to completion; cycle numbers recorded relative to the start.
  task automatic runProgram(input int limit);
    int idx, gapLeft, base, spent;
    bit v;
    idx = 0; gapLeft = (nInstr > 0) ? pGap[0] : 0;
    base = cyc; spent = 0;
    for (int i = 0; i < MAXI; i++) begin
      issueCyc[i] = -1; readCyc[i] = -1; doneCyc[i] = -1; writeCyc[i] = -1; tagRec[i] = -1;
    end
    while (idx < nInstr || !eQuiet || spent == 0) begin
      @(negedge clk);
      cyc++; spent++;
      v = (idx < nInstr) && (gapLeft == 0);
      if (idx < nInstr && gapLeft > 0) gapLeft--;
      inValid = v;
      inOp   = v ? 2'(pOp[idx]) : 2'd0;
      inDest = v ? 5'(pD[idx])  : 5'd0;
      inSrc1 = v ? 5'(pS1[idx]) : 5'd0;
      inSrc2 = v ? 5'(pS2[idx]) : 5'd0;
      #1;
      modelEval(v, v ? pOp[idx] : 0, v ? pD[idx] : 0);
      compareAll();
      for (int u = 0; u < NU; u++) begin
        if (unitInst[u] >= 0) begin
          if (readGrant[u])  readCyc[unitInst[u]]  = cyc - base;
          if (unitDone[u])   doneCyc[unitInst[u]]  = cyc - base;
          if (writeGrant[u]) writeCyc[unitInst[u]] = cyc - base;
        end
      end
      modelAdvance(v, v ? pOp[idx] : -1, v ? pD[idx] : 0, v ? pS1[idx] : 0, v ? pS2[idx] : 0);
      if (v && inReady) begin
        issueCyc[idx] = cyc - base;
        tagRec[idx] = issueTag;
        if (issueTag >= 1 && issueTag <= 5) unitInst[issueTag-1] = idx;
        idx++;
        if (idx < nInstr) gapLeft = pGap[idx];
      end
      if (spent > limit) begin
        chk("R2", "program completes within limit", 0, 1);
        break;
      end
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic addInstr(input int op, input int d, input int s1, input int s2, input int gap);
    pOp[nInstr] = op; pD[nInstr] = d; pS1[nInstr] = s1; pS2[nInstr] = s2; pGap[nInstr] = gap;
    nInstr++;
  endtask

  task automatic chkStages(input int i, input int iss, input int rd, input int dn, input int wr);
    chk("R2", $sformatf("instr %0d issue cycle", i), issueCyc[i], iss);
    chk("R4", $sformatf("instr %0d read cycle", i), readCyc[i], rd);
    chk("R7", $sformatf("instr %0d done cycle", i), doneCyc[i], dn);
    chk("R5", $sformatf("instr %0d write cycle", i), writeCyc[i], wr);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int u = 0; u < NU; u++) unitInst[u] = -1;
    modelReset();

    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "quiescent in reset", quiescent, 1);
    chk("R1", "writeGrant in reset", writeGrant, 0);
    chk("R1", "readGrant in reset", readGrant, 0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk("R1", "quiescent after reset", quiescent, 1);
    chk("R1", "inReady idle", inReady, 1);
    chk("R1", "issueTag idle", issueTag, 0);
    chk("R1", "execStart idle", execStart, 0);
    chk("R1", "unitDone idle", unitDone, 0);

    // Classic load/multiply/subtract/divide/add sequence
    nInstr = 0;
    addInstr(0, 6, 20, 20, 0);   // load  F6
    addInstr(0, 2, 21, 21, 0);   // load  F2
    addInstr(1, 0, 2, 4, 0);     // mul   F0 <- F2,F4
    addInstr(2, 8, 6, 2, 0);     // sub   F8 <- F6,F2
    addInstr(3, 10, 0, 6, 0);    // div   F10 <- F0,F6
    addInstr(2, 6, 8, 2, 0);     // add   F6 <- F8,F2
    runProgram(500);
    chkStages(0, 1, 2, 3, 4);
    chkStages(1, 5, 6, 7, 8);
    chkStages(2, 6, 9, 19, 20);
    chkStages(3, 7, 9, 11, 12);
    chkStages(4, 8, 21, 61, 62);
    chkStages(5, 13, 14, 16, 22);   // R5: write held until the divide reads F6
    chk("R3", "mul gets tag 2", tagRec[2], 2);
    chk("R3", "div gets tag 5", tagRec[4], 5);

    // Directed: simultaneous writes, same-cycle bypass, WAW stall, in-order stall
    nInstr = 0;
    addInstr(2, 3, 20, 21, 0);   // 0 add F3
    addInstr(0, 5, 20, 20, 0);   // 1 int F5
    addInstr(1, 12, 3, 3, 2);    // 2 mul F12 <- F3 (accepted as add writes)
    addInstr(3, 12, 20, 20, 0);  // 3 div F12: WAW stall
    addInstr(0, 13, 20, 20, 0);  // 4 int stuck behind 3
    addInstr(1, 14, 20, 20, 0);  // 5 mul
    addInstr(1, 15, 20, 20, 0);  // 6 mul
    runProgram(500);
    chk("R8", "add write cycle", writeCyc[0], 5);
    chk("R8", "int write cycle", writeCyc[1], 5);
    chk("R6", "mul accepted during producer write", issueCyc[2], 5);
    chk("R6", "mul read right after", readCyc[2], 6);
    chk("R7", "mul done", doneCyc[2], 16);
    chk("R2", "WAW divide issue", issueCyc[3], 18);
    chk("R2", "in-order int issue", issueCyc[4], 19);
    chk("R7", "int write", writeCyc[4], 22);
    chk("R3", "first free mul tag", tagRec[5], 2);
    chk("R3", "second mul tag", tagRec[6], 3);

    // Pseudo-random stream over a small register set for dense hazards
    nInstr = 0;
    for (int i = 0; i < 400; i++) begin
      addInstr($urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 7),
               $urandom_range(0, 7), ($urandom_range(0, 1) == 0) ? 0 : $urandom_range(0, 2));
    end
    runProgram(60000);
    chk("R9", "quiescent at end", quiescent, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule